// File: doc/BRIEF.md
# Partitioned Secure Scratch RAM Controller

This block fronts an on-chip scratch memory that is cut into equal pages. Each page is either free or held by one partition, which the block records as a domain tag and a secure flag. Every bus request carries the requester's domain tag and a secure bit. The controller completes the request only if the target page is held, the domain tags match, and the privilege is high enough. Any other request ends in an error response and has no effect on memory.

A separate manager port hands pages to partitions and takes them back. Only a request marked privileged can do this. A page that is taken back is cleared to zero, one word per cycle, before it can be handed out again. A security-violation input drops every ownership and walks the whole array writing zeros. It raises a done flag when the walk finishes. All traffic is refused while either kind of clearing runs.

With default parameters the block holds 64 KB as 16 pages of 4 KB, stored in 128-bit words. A bus address is the page index in its upper bits followed by the word offset inside the page.

Top module: `secure_page_ram`

## Requirements
- R1: After reset no page is owned, wipeBusy and wipeDone are 0, and every bus request gets an error response.
- R2: A bus request is answered on busAck exactly one cycle after the cycle it is presented in. An accepted write stores busWdata at busAddr. An accepted read returns the stored word on busRdata in that answer cycle. The page index is busAddr divided by PAGE_WORDS.
- R3: A bus request to a page that is not owned, or whose owning domain tag differs from busDid, gets busErr = 1.
- R4: On a page whose secure flag is 1, a request with busSecure = 0 gets busErr = 1. A request with busSecure = 1 is accepted on a matching page whether its flag is 0 or 1.
- R5: A rejected write leaves memory unchanged. busRdata is zero in the answer cycle of every request other than an accepted read.
- R6: A privileged manager assign (mgrRelease = 0) to a free page answers mgrAck = 1, mgrErr = 0 one cycle later and records mgrDid and mgrSecure as the page's owner. An assign to a page that is already owned gets mgrErr = 1 and changes nothing.
- R7: A manager request with mgrPriv = 0 gets mgrErr = 1 and leaves every page's ownership unchanged.
- R8: A privileged release (mgrRelease = 1) of an owned page frees it and then writes zero to its PAGE_WORDS words over the next PAGE_WORDS cycles. While this runs, every bus and manager request is rejected. The first request accepted again is the one presented PAGE_WORDS+1 cycles after the release. A release of a free page gets mgrErr = 1.
- R9: When secViol is 1 in a cycle, every ownership is dropped and any request in that same cycle is rejected. From the next cycle, wipeBusy stays 1 for exactly NUM_PAGES*PAGE_WORDS cycles while every word is set to zero, and all requests are rejected. wipeDone is 0 while the walk runs, becomes 1 when it ends, and stays 1 until the next violation.
- R10: A violation that arrives during a wipe restarts the walk at address 0, so wipeBusy stays 1 for a further full NUM_PAGES*PAGE_WORDS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busReq | input | 1 | Bus request valid for one cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Word address: page index then offset |
| busWdata | input | DATA_W | Write data |
| busDid | input | DID_W | Requester domain tag |
| busSecure | input | 1 | Requester secure privilege |
| busAck | output | 1 | Response strobe, one cycle after busReq |
| busErr | output | 1 | Response is an error |
| busRdata | output | DATA_W | Read data, zero unless an accepted read |
| mgrReq | input | 1 | Manager request valid |
| mgrRelease | input | 1 | 1 = release page, 0 = assign page |
| mgrPage | input | PG_W | Target page index |
| mgrDid | input | DID_W | Domain tag to record on assign |
| mgrSecure | input | 1 | Secure flag to record on assign |
| mgrPriv | input | 1 | Request comes from the privileged manager |
| mgrAck | output | 1 | Manager response strobe |
| mgrErr | output | 1 | Manager request refused |
| secViol | input | 1 | Security violation event |
| wipeBusy | output | 1 | Full-memory zero walk in progress |
| wipeDone | output | 1 | Last full walk completed |

## Verification
A corrupted ownership entry shows up on the very next bus answer to that page as a wrong busErr. Because of this, the bench sweeps every domain tag and privilege value against every page. A stale word left behind by a clearing walk, or a rejected write that slipped through, only appears at the next accepted read of that address. The bench therefore reads back whole pages after release, after a wipe and after refused writes. A walk counter that skips or stalls changes the length of the wipeBusy window and the cycle at which a release stops refusing requests. Both of these are measured to the exact cycle.

// File: rtl/spr_pkg.sv
package spr_pkg;

  // Strobes from the control unit to the storage datapath
  typedef struct packed {
    logic wrEn;    // write the addressed word
    logic zeroWr;  // write zero instead of bus data
    logic rdEn;    // capture the addressed word into the read register
    logic clrRd;   // force the read register to zero
  } memStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WIPE  = 2'd1,
    ST_SCRUB = 2'd2
  } ctlState_t;

endpackage

// File: rtl/spr_datapath.sv
module spr_datapath
  import spr_pkg::*;
#(
  parameter int NUM_PAGES  = 16,
  parameter int PAGE_WORDS = 256,
  parameter int DATA_W     = 128
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  memStrobe_t                                  strobe,
  input  logic [$clog2(NUM_PAGES*PAGE_WORDS)-1:0]     memAddr,
  input  logic [DATA_W-1:0]                           wData,
  output logic [DATA_W-1:0]                           rData
);

  localparam int DEPTH  = NUM_PAGES * PAGE_WORDS;

  logic [DATA_W-1:0] storage [DEPTH];
  logic [DATA_W-1:0] rdReg;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      storage[memAddr] <= strobe.zeroWr ? '0 : wData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdReg <= '0;
    end else if (strobe.rdEn) begin
      rdReg <= storage[memAddr];
    end else if (strobe.clrRd) begin
      rdReg <= '0;
    end
  end

  assign rData = rdReg;

  // A single storage port: never read and write in one cycle (R5)
  assert_single_port_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrEn && strobe.rdEn));

  // Zero writes only happen as writes (R9)
  assert_zero_is_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zeroWr |-> strobe.wrEn);

endmodule

// File: rtl/spr_ctrl.sv
module spr_ctrl
  import spr_pkg::*;
#(
  parameter int NUM_PAGES  = 16,
  parameter int PAGE_WORDS = 256,
  parameter int DID_W      = 4
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  logic                                        busReq,
  input  logic                                        busWe,
  input  logic [$clog2(NUM_PAGES*PAGE_WORDS)-1:0]     busAddr,
  input  logic [DID_W-1:0]                            busDid,
  input  logic                                        busSecure,
  output logic                                        busAck,
  output logic                                        busErr,
  input  logic                                        mgrReq,
  input  logic                                        mgrRelease,
  input  logic [$clog2(NUM_PAGES)-1:0]                mgrPage,
  input  logic [DID_W-1:0]                            mgrDid,
  input  logic                                        mgrSecure,
  input  logic                                        mgrPriv,
  output logic                                        mgrAck,
  output logic                                        mgrErr,
  input  logic                                        secViol,
  output logic                                        wipeBusy,
  output logic                                        wipeDone,
  output memStrobe_t                                  strobe,
  output logic [$clog2(NUM_PAGES*PAGE_WORDS)-1:0]     memAddr
);

  localparam int DEPTH  = NUM_PAGES * PAGE_WORDS;
  localparam int OFF_W  = $clog2(PAGE_WORDS);
  localparam int PG_W   = $clog2(NUM_PAGES);
  localparam int ADDR_W = OFF_W + PG_W;

  ctlState_t           state;
  logic [ADDR_W-1:0]   walkCnt;
  logic [PG_W-1:0]     scrubPage;
  logic [NUM_PAGES-1:0] ownValid;
  logic [NUM_PAGES-1:0] ownSec;
  logic [DID_W-1:0]    ownDid [NUM_PAGES];

  logic [PG_W-1:0]     busPage;
  logic                isIdle;
  logic                accOk;
  logic                mgrOk;
  logic                walkLast;

  assign busPage = busAddr[ADDR_W-1:OFF_W];
  assign isIdle  = (state == ST_IDLE);

  // Access check: owned page, same domain, enough privilege
  assign accOk = busReq && isIdle && !secViol
              && ownValid[busPage]
              && (ownDid[busPage] == busDid)
              && (busSecure || !ownSec[busPage]);

  // Manager check: privileged, idle, and page state fits the operation
  assign mgrOk = mgrReq && isIdle && !secViol && mgrPriv
              && (mgrRelease ? ownValid[mgrPage] : !ownValid[mgrPage]);

  assign walkLast = (state == ST_WIPE)
                  ? (walkCnt == ADDR_W'(DEPTH - 1))
                  : (walkCnt[OFF_W-1:0] == OFF_W'(PAGE_WORDS - 1));

  // Strobes and address toward the datapath
  always_comb begin
    strobe  = '0;
    memAddr = busAddr;
    strobe.clrRd = busReq && !(accOk && !busWe);
    if (state == ST_WIPE) begin
      strobe.wrEn   = 1'b1;
      strobe.zeroWr = 1'b1;
      memAddr       = walkCnt;
    end else if (state == ST_SCRUB) begin
      strobe.wrEn   = 1'b1;
      strobe.zeroWr = 1'b1;
      memAddr       = {scrubPage, walkCnt[OFF_W-1:0]};
    end else if (accOk) begin
      strobe.wrEn = busWe;
      strobe.rdEn = !busWe;
    end
  end

  // Sequencer and ownership table
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      walkCnt   <= '0;
      scrubPage <= '0;
      wipeDone  <= 1'b0;
      ownValid  <= '0;
      ownSec    <= '0;
      for (int p = 0; p < NUM_PAGES; p++) ownDid[p] <= '0;
    end else if (secViol) begin
      state    <= ST_WIPE;
      walkCnt  <= '0;
      wipeDone <= 1'b0;
      ownValid <= '0;
    end else begin
      unique case (state)
        ST_WIPE: begin
          if (walkLast) begin
            state    <= ST_IDLE;
            walkCnt  <= '0;
            wipeDone <= 1'b1;
          end else begin
            walkCnt <= walkCnt + 1'b1;
          end
        end
        ST_SCRUB: begin
          if (walkLast) begin
            state   <= ST_IDLE;
            walkCnt <= '0;
          end else begin
            walkCnt <= walkCnt + 1'b1;
          end
        end
        default: begin
          if (mgrOk) begin
            if (mgrRelease) begin
              ownValid[mgrPage] <= 1'b0;
              scrubPage         <= mgrPage;
              walkCnt           <= '0;
              state             <= ST_SCRUB;
            end else begin
              ownValid[mgrPage] <= 1'b1;
              ownSec[mgrPage]   <= mgrSecure;
              ownDid[mgrPage]   <= mgrDid;
            end
          end
        end
      endcase
    end
  end

  // Registered responses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAck <= 1'b0;
      busErr <= 1'b0;
      mgrAck <= 1'b0;
      mgrErr <= 1'b0;
    end else begin
      busAck <= busReq;
      busErr <= busReq && !accOk;
      mgrAck <= mgrReq;
      mgrErr <= mgrReq && !mgrOk;
    end
  end

  assign wipeBusy = (state == ST_WIPE);

  assert_wipe_rejects_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WIPE && busReq) |=> (busAck && busErr));

  assert_unowned_rejects_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !ownValid[busPage]) |=> busErr);

  assert_nonpriv_keeps_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mgrReq && !mgrPriv && !secViol) |=> (mgrErr && ownValid == $past(ownValid)));

  assert_viol_restart_R10: assert property (@(posedge clk) disable iff (!rstN)
    secViol |=> (state == ST_WIPE && walkCnt == '0 && ownValid == '0));

  assert_walk_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && !secViol && !walkLast) |=> (walkCnt == $past(walkCnt) + 1'b1));

  assert_release_scrub_R8: assert property (@(posedge clk) disable iff (!rstN)
    (mgrOk && mgrRelease) |=> (state == ST_SCRUB && !ownValid[$past(mgrPage)]));

endmodule

// File: rtl/secure_page_ram.sv
module secure_page_ram
  import spr_pkg::*;
#(
  parameter int NUM_PAGES  = 16,
  parameter int PAGE_WORDS = 256,
  parameter int DATA_W     = 128,
  parameter int DID_W      = 4,
  localparam int PG_W      = $clog2(NUM_PAGES),
  localparam int ADDR_W    = $clog2(NUM_PAGES * PAGE_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DID_W-1:0]  busDid,
  input  logic              busSecure,
  output logic              busAck,
  output logic              busErr,
  output logic [DATA_W-1:0] busRdata,
  input  logic              mgrReq,
  input  logic              mgrRelease,
  input  logic [PG_W-1:0]   mgrPage,
  input  logic [DID_W-1:0]  mgrDid,
  input  logic              mgrSecure,
  input  logic              mgrPriv,
  output logic              mgrAck,
  output logic              mgrErr,
  input  logic              secViol,
  output logic              wipeBusy,
  output logic              wipeDone
);

  memStrobe_t        strobe;
  logic [ADDR_W-1:0] memAddr;

  spr_ctrl #(
    .NUM_PAGES (NUM_PAGES),
    .PAGE_WORDS(PAGE_WORDS),
    .DID_W     (DID_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busReq    (busReq),
    .busWe     (busWe),
    .busAddr   (busAddr),
    .busDid    (busDid),
    .busSecure (busSecure),
    .busAck    (busAck),
    .busErr    (busErr),
    .mgrReq    (mgrReq),
    .mgrRelease(mgrRelease),
    .mgrPage   (mgrPage),
    .mgrDid    (mgrDid),
    .mgrSecure (mgrSecure),
    .mgrPriv   (mgrPriv),
    .mgrAck    (mgrAck),
    .mgrErr    (mgrErr),
    .secViol   (secViol),
    .wipeBusy  (wipeBusy),
    .wipeDone  (wipeDone),
    .strobe    (strobe),
    .memAddr   (memAddr)
  );

  spr_datapath #(
    .NUM_PAGES (NUM_PAGES),
    .PAGE_WORDS(PAGE_WORDS),
    .DATA_W    (DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .memAddr(memAddr),
    .wData  (busWdata),
    .rData  (busRdata)
  );

endmodule

// File: tb/secure_page_ram_tb.sv
module secure_page_ram_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NP   = 4;
  localparam int PW   = 8;
  localparam int DW   = 16;
  localparam int DIDW = 2;
  localparam int TOTAL = NP * PW;
  localparam int AW   = $clog2(TOTAL);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReq = 0, busWe = 0, busSecure = 0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DIDW-1:0] busDid = '0;
  logic busAck, busErr;
  logic [DW-1:0] busRdata;
  logic mgrReq = 0, mgrRelease = 0, mgrSecure = 0, mgrPriv = 0;
  logic [1:0] mgrPage = '0;
  logic [DIDW-1:0] mgrDid = '0;
  logic mgrAck, mgrErr;
  logic secViol = 0;
  logic wipeBusy, wipeDone;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic rAck, rErr;
  logic [DW-1:0] rData;

  always #(CLK_PERIOD/2) clk = ~clk;

  secure_page_ram #(.NUM_PAGES(NP), .PAGE_WORDS(PW), .DATA_W(DW), .DID_W(DIDW)) u_dut (
    .clk(clk), .rstN(rstN),
    .busReq(busReq), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busDid(busDid), .busSecure(busSecure), .busAck(busAck), .busErr(busErr),
    .busRdata(busRdata),
    .mgrReq(mgrReq), .mgrRelease(mgrRelease), .mgrPage(mgrPage), .mgrDid(mgrDid),
    .mgrSecure(mgrSecure), .mgrPriv(mgrPriv), .mgrAck(mgrAck), .mgrErr(mgrErr),
    .secViol(secViol), .wipeBusy(wipeBusy), .wipeDone(wipeDone)
  );

  function automatic logic [DW-1:0] patt(input int a);
    return DW'(a * 313 + 23100);
  endfunction

  function automatic int ownerDid(input int p);
    return (p + 1) % 4;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; presents one request for one cycle, samples the answer
  task automatic busOp(input bit we, input int addr, input int wd, input int did, input bit sec);
    busReq = 1; busWe = we; busAddr = AW'(addr); busWdata = DW'(wd);
    busDid = DIDW'(did); busSecure = sec;
    @(negedge clk);
    rAck = busAck; rErr = busErr; rData = busRdata;
    busReq = 0; busWe = 0;
  endtask

  task automatic mgrOp(input bit rel, input int pg, input int did, input bit sec, input bit priv);
    mgrReq = 1; mgrRelease = rel; mgrPage = 2'(pg); mgrDid = DIDW'(did);
    mgrSecure = sec; mgrPriv = priv;
    @(negedge clk);
    rAck = mgrAck; rErr = mgrErr;
    mgrReq = 0; mgrRelease = 0; mgrPriv = 0;
  endtask

  task automatic violPulse();
    secViol = 1;
    @(negedge clk);
    secViol = 0;
  endtask

  task automatic countBusy(output int n);
    n = 0;
    while (wipeBusy && n < 10 * TOTAL) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: reset state
    chk(wipeBusy == 0 && wipeDone == 0, "R1 flags after reset", {wipeBusy, wipeDone}, 0);
    busOp(0, 0, 0, 0, 1);
    chk(rAck && rErr, "R1 access after reset", {rAck, rErr}, 3);
    chk(rData == 0, "R5 rejected read data", rData, 0);

    // R9: full wipe length and done flag
    violPulse();
    chk(wipeDone == 0, "R9 done low during walk", wipeDone, 0);
    countBusy(n);
    chk(n == TOTAL, "R9 wipe length", n, TOTAL);
    chk(wipeDone == 1, "R9 done after walk", wipeDone, 1);

    // R6: assign every page
    for (int p = 0; p < NP; p++) begin
      mgrOp(0, p, ownerDid(p), p[0], 1);
      chk(rAck && !rErr, "R6 assign free page", {rAck, rErr}, 2);
    end
    mgrOp(0, 0, 3, 0, 1);
    chk(rErr, "R6 assign owned page", rErr, 1);
    busOp(0, 0, 0, ownerDid(0), 0);
    chk(!rErr, "R6 owner unchanged", rErr, 0);

    // R7: non-privileged manager has no effect
    mgrOp(1, 1, 0, 0, 0);
    chk(rErr, "R7 nonpriv release", rErr, 1);
    mgrOp(0, 1, 0, 0, 0);
    chk(rErr, "R7 nonpriv assign", rErr, 1);
    busOp(0, 9, 0, ownerDid(1), 1);
    chk(!rErr, "R7 page still owned", rErr, 0);

    // R2: write and read every word as its owner
    for (int a = 0; a < TOTAL; a++) begin
      busOp(1, a, patt(a), ownerDid(a / PW), 1);
      chk(rAck && !rErr, "R2 owner write", {rAck, rErr}, 2);
      chk(rData == 0, "R5 write answer data", rData, 0);
    end
    for (int a = 0; a < TOTAL; a++) begin
      busOp(0, a, 0, ownerDid(a / PW), 1);
      chk(!rErr && rData == patt(a), "R2 owner read", rData, patt(a));
    end

    // R3/R4/R5: sweep domains and privilege against each page
    for (int p = 0; p < NP; p++) begin
      for (int d = 0; d < 4; d++) begin
        for (int s = 0; s < 2; s++) begin
          bit ok;
          int a;
          a  = p * PW + 3;
          ok = (d == ownerDid(p)) && (s == 1 || p[0] == 0);
          busOp(0, a, 0, d, s[0]);
          chk(rErr == !ok, "R3 R4 access decision", rErr, !ok);
          chk(rData == (ok ? patt(a) : 0), "R5 read data by decision", rData, ok ? patt(a) : 0);
        end
      end
    end

    // R5: rejected writes leave memory untouched
    busOp(1, 12, 16'hDEAD, ownerDid(1), 0);
    chk(rErr, "R4 nonsecure write to secure page", rErr, 1);
    busOp(1, 12, 16'hBEEF, 0, 1);
    chk(rErr, "R3 foreign domain write", rErr, 1);
    busOp(0, 12, 0, ownerDid(1), 1);
    chk(rData == patt(12), "R5 memory unchanged", rData, patt(12));

    // R8: release page 2, scrub window timing
    mgrOp(1, 2, 0, 0, 1);
    chk(rAck && !rErr, "R8 release owned page", {rAck, rErr}, 2);
    busOp(0, 1, 0, ownerDid(0), 1);
    chk(rErr, "R8 bus rejected during scrub", rErr, 1);
    mgrOp(0, 2, 1, 0, 1);
    chk(rErr, "R8 assign rejected during scrub", rErr, 1);
    repeat (PW - 3) @(negedge clk);
    mgrOp(0, 2, 1, 0, 1);
    chk(rErr, "R8 last scrub cycle rejects", rErr, 1);
    mgrOp(0, 2, 1, 0, 1);
    chk(!rErr, "R8 first cycle after scrub accepts", rErr, 0);
    for (int o = 0; o < PW; o++) begin
      busOp(0, 2 * PW + o, 0, 1, 0);
      chk(!rErr && rData == 0, "R8 released page zeroed", rData, 0);
    end
    busOp(0, 3 * PW + 5, 0, ownerDid(3), 1);
    chk(rData == patt(3 * PW + 5), "R8 other page intact", rData, patt(3 * PW + 5));

    // R9/R10: violation with same-cycle write, then restart during walk
    secViol = 1;
    busOp(1, 4, 16'h1234, ownerDid(0), 1);
    secViol = 0;
    chk(rErr, "R9 same-cycle access rejected", rErr, 1);
    busOp(0, 4, 0, ownerDid(0), 1);
    chk(rErr, "R9 access during wipe", rErr, 1);
    repeat (4) @(negedge clk);
    violPulse();
    countBusy(n);
    chk(n == TOTAL, "R10 restarted wipe length", n, TOTAL);
    chk(wipeDone == 1, "R9 done after restart", wipeDone, 1);
    busOp(0, 9, 0, ownerDid(1), 1);
    chk(rErr, "R9 ownership dropped", rErr, 1);
    mgrOp(1, 0, 0, 0, 1);
    chk(rErr, "R8 release free page", rErr, 1);
    mgrOp(0, 0, 2, 1, 1);
    chk(!rErr, "R6 assign after wipe", rErr, 0);
    for (int a = 0; a < PW; a++) begin
      busOp(0, a, 0, 2, 1);
      chk(!rErr && rData == 0, "R9 memory zeroed", rData, 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule